// File: doc/BRIEF.md
# Handshaked Register Value Synchronizer

This block carries a multi-bit register value from a source clock domain into a destination clock domain. The source side writes the register through a write strobe. The destination side always reads a registered copy. The two clocks may have any frequency and phase relation.

A word is never synchronized bit by bit. An accepted write latches the whole word into a source-side holding register and flips a one-bit request level. Only that single level crosses into the destination domain, through a flop chain. When the destination sees the level change, it copies the holding register into its output register in one cycle. The holding register has been stable for several cycles by then, so every bit is taken from the same word.

The destination returns its captured level to the source through a second flop chain as an acknowledge. The write port reports ready only while the acknowledge equals the request level. A new word therefore cannot replace the holding register while the previous one is still crossing. The block guarantees delivery of each accepted word to the destination register. It does not guarantee that logic behind that register observes every word. The source reset also resets the destination side: it asserts there at once and is released through its own flop chain.

Top module: `regsync_handshake`

## Requirements
- R1: While src_rst_n is low and after its release, before any write has been delivered, dst_rd_data equals the INIT_VALUE parameter and src_wr_ready is 1.
- R2: A write is accepted on a src_clk rising edge where src_wr_en and src_wr_ready are both 1. src_wr_ready is 0 in the src_clk cycle that follows an accepted write.
- R3: A src_wr_en pulse while src_wr_ready is 0 is ignored: its data never appears on dst_rd_data, and the word in flight is not disturbed.
- R4: dst_rd_data only ever takes the value INIT_VALUE or a word that was accepted. It takes the accepted words whole, in order of acceptance, and after the source goes idle it settles on the last accepted word.
- R5: An accepted word appears on dst_rd_data no more than SYNC_STAGES+3 dst_clk rising edges after the src_clk cycle in which it was offered.
- R6: Asserting src_rst_n low in the middle of a transfer returns dst_rd_data to INIT_VALUE and src_wr_ready to 1, and transfers work normally after release.
- R7: src_wr_ready returns to 1 after each delivery, so a source that keeps writing goes on making progress at every clock ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Active-low asynchronous reset for both domains, asserted from the source side |
| src_wr_en | input | 1 | Write strobe, source domain |
| src_wr_data | input | WIDTH | Word to write, source domain |
| src_wr_ready | output | 1 | High when a write will be accepted |
| dst_clk | input | 1 | Destination domain clock |
| dst_rd_data | output | WIDTH | Registered copy of the last delivered word, destination domain |

## Verification
The bench builds the block with a 24-bit word, a non-zero initial value and three synchronizer stages instead of the default two. This exercises the stage-count generate path and makes the latency bound of R5 depend on the parameter. The destination clock runs at several ratios to the source clock:
- equal frequency;
- slower by about three times;
- faster by more than two times;
- slower by about six times.

At these ratios words arrive while the source keeps offering writes that must be ignored. The bench also applies a reset while a word is in flight.

// File: rtl/regsync_pkg.sv
package regsync_pkg;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_SYNC_STAGES = 6;

   // One-bit handshake level carried across the domains.
   typedef logic hs_level_t;

   function automatic logic levels_match(input hs_level_t a, input hs_level_t b);
      return (a == b);
   endfunction

   function automatic hs_level_t level_flip(input hs_level_t a);
      return ~a;
   endfunction

endpackage

// File: rtl/regsync_sync_chain.sv
module regsync_sync_chain #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import regsync_pkg::*;

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < MIN_SYNC_STAGES || STAGES > MAX_SYNC_STAGES) begin : g_bad_stages
      $error("regsync_sync_chain: STAGES out of range");
   end

   logic [LAST:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= RST_VAL;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q = chain_q[LAST];

endmodule

// File: rtl/regsync_rst_sync.sv
module regsync_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n_o
);
   import regsync_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("regsync_rst_sync: STAGES below minimum");
   end

   // Asserts asynchronously, releases on the local clock.
   regsync_sync_chain #(
      .STAGES  (STAGES),
      .RST_VAL (1'b0)
   ) u_chain (
      .clk   (clk),
      .rst_n (arst_n),
      .d     (1'b1),
      .q     (rst_n_o)
   );

endmodule

// File: rtl/regsync_src.sv
module regsync_src #(
   parameter int unsigned           WIDTH       = 32,
   parameter logic [WIDTH-1:0]      INIT_VALUE  = '0,
   parameter int unsigned           SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             ack_async,
   output logic             wr_ready,
   output logic [WIDTH-1:0] hold_o,
   output logic             req_o
);
   import regsync_pkg::*;

   if (WIDTH < 1) begin : g_bad_width
      $error("regsync_src: WIDTH must be positive");
   end

   logic [WIDTH-1:0] hold_q;
   hs_level_t        req_q;
   hs_level_t        ack_s;
   logic             accept;

   regsync_sync_chain #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_ack_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ack_async),
      .q     (ack_s)
   );

   assign wr_ready = levels_match(req_q, ack_s);
   assign accept   = wr_en & wr_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= INIT_VALUE;
         req_q  <= 1'b0;
      end else if (accept) begin
         hold_q <= wr_data;
         req_q  <= level_flip(req_q);
      end
   end

   assign hold_o = hold_q;
   assign req_o  = req_q;

   // R2: an accepted write closes the port for the next cycle
   a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ready) |=> !wr_ready);

   // R3: the holding register does not move while a word is in flight
   a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |=> $stable(hold_q));

   // R3: the request level does not move while a word is in flight
   a_r3_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ready |=> $stable(req_q));

endmodule

// File: rtl/regsync_dst.sv
module regsync_dst #(
   parameter int unsigned           WIDTH       = 32,
   parameter logic [WIDTH-1:0]      INIT_VALUE  = '0,
   parameter int unsigned           SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] hold_i,
   input  logic             req_async,
   output logic             ack_o,
   output logic [WIDTH-1:0] rd_data
);
   import regsync_pkg::*;

   logic             rst_n;
   hs_level_t        req_s;
   hs_level_t        seen_q;
   logic [WIDTH-1:0] out_q;
   logic             arrive;

   regsync_rst_sync #(
      .STAGES (SYNC_STAGES)
   ) u_rst_sync (
      .clk     (clk),
      .arst_n  (arst_n),
      .rst_n_o (rst_n)
   );

   regsync_sync_chain #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b0)
   ) u_req_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_async),
      .q     (req_s)
   );

   assign arrive = !levels_match(req_s, seen_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= 1'b0;
         out_q  <= INIT_VALUE;
      end else if (arrive) begin
         seen_q <= req_s;
         out_q  <= hold_i;
      end
   end

   assign ack_o   = seen_q;
   assign rd_data = out_q;

   // R4: the output moves only when a new request level has arrived
   a_r4_out_only_on_arrival: assert property (@(posedge clk) disable iff (!rst_n)
      (req_s == seen_q) |=> $stable(out_q));

   // R4: on arrival the whole held word is taken in one cycle
   a_r4_whole_word: assert property (@(posedge clk) disable iff (!rst_n)
      (req_s != seen_q) |=> (out_q == $past(hold_i)));

endmodule

// File: rtl/regsync_handshake.sv
module regsync_handshake #(
   parameter int unsigned      WIDTH       = 32,
   parameter logic [WIDTH-1:0] INIT_VALUE  = '0,
   parameter int unsigned      SYNC_STAGES = 2
) (
   input  logic             src_clk,
   input  logic             src_rst_n,
   input  logic             src_wr_en,
   input  logic [WIDTH-1:0] src_wr_data,
   output logic             src_wr_ready,
   input  logic             dst_clk,
   output logic [WIDTH-1:0] dst_rd_data
);
   import regsync_pkg::*;

   if (SYNC_STAGES < MIN_SYNC_STAGES || SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_stages
      $error("regsync_handshake: SYNC_STAGES out of range");
   end

   logic [WIDTH-1:0] hold_w;
   hs_level_t        req_w;
   hs_level_t        ack_w;

   regsync_src #(
      .WIDTH       (WIDTH),
      .INIT_VALUE  (INIT_VALUE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_src (
      .clk       (src_clk),
      .rst_n     (src_rst_n),
      .wr_en     (src_wr_en),
      .wr_data   (src_wr_data),
      .ack_async (ack_w),
      .wr_ready  (src_wr_ready),
      .hold_o    (hold_w),
      .req_o     (req_w)
   );

   regsync_dst #(
      .WIDTH       (WIDTH),
      .INIT_VALUE  (INIT_VALUE),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_dst (
      .clk       (dst_clk),
      .arst_n    (src_rst_n),
      .hold_i    (hold_w),
      .req_async (req_w),
      .ack_o     (ack_w),
      .rd_data   (dst_rd_data)
   );

   // R1: reset leaves the write port open
   a_r1_ready_in_reset: assert property (@(posedge src_clk)
      !src_rst_n |-> src_wr_ready);

endmodule

// File: tb/regsync_handshake_tb.sv
`timescale 1ns/100ps
module regsync_handshake_tb;
   localparam int unsigned W = 24;
   localparam int unsigned S = 3;
   localparam logic [W-1:0] INIT = 24'h5A3C81;

   logic          src_clk = 1'b0;
   logic          dst_clk = 1'b0;
   logic          src_rst_n = 1'b0;
   logic          src_wr_en = 1'b0;
   logic [W-1:0]  src_wr_data = '0;
   logic          src_wr_ready;
   logic [W-1:0]  dst_rd_data;

   realtime dst_half = 4.0;

   always #4 src_clk = ~src_clk;
   always #(dst_half) dst_clk = ~dst_clk;

   regsync_handshake #(
      .WIDTH       (W),
      .INIT_VALUE  (INIT),
      .SYNC_STAGES (S)
   ) u_dut (
      .src_clk      (src_clk),
      .src_rst_n    (src_rst_n),
      .src_wr_en    (src_wr_en),
      .src_wr_data  (src_wr_data),
      .src_wr_ready (src_wr_ready),
      .dst_clk      (dst_clk),
      .dst_rd_data  (dst_rd_data)
   );

   int compared = 0;
   int mismatched = 0;
   int dcount = 0;
   int accepted = 0;
   int ignored = 0;
   bit model_on = 1'b0;
   logic [W-1:0] cur = INIT;
   logic [W-1:0] last = INIT;
   logic [W-1:0] q[$];
   int stamp[$];

   task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge dst_clk) dcount++;

   // Reference model: the output is the current word or the next queued one.
   always @(negedge dst_clk) begin
      if (model_on) begin
         if (dst_rd_data == cur) begin
            check(1'b1, "R4", dst_rd_data, cur);
         end else if (q.size() > 0 && dst_rd_data == q[0]) begin
            check((dcount - stamp[0]) <= int'(S) + 3, "R5",
                  W'(dcount - stamp[0]), W'(S + 3));
            cur = q.pop_front();
            void'(stamp.pop_front());
         end else begin
            check(1'b0, "R4", dst_rd_data, (q.size() > 0) ? q[0] : cur);
         end
      end
   end

   function automatic logic [W-1:0] fresh_word(input logic [W-1:0] avoid);
      logic [W-1:0] v;
      v = W'($urandom);
      while (v == avoid || v == INIT) v = W'($urandom);
      return v;
   endfunction

   task automatic drain(input string req);
      int n;
      n = 0;
      while ((q.size() > 0 || !src_wr_ready) && n < 600) begin
         @(negedge src_clk);
         n++;
      end
      check(src_wr_ready === 1'b1, "R7", W'(src_wr_ready), W'(1));
      repeat (4 * S + 4) @(negedge dst_clk);
      check(dst_rd_data == last, req, dst_rd_data, last);
   endtask

   task automatic run_phase(input realtime half, input int n);
      bit just;
      dst_half = half;
      just = 1'b0;
      repeat (n) begin
         @(negedge src_clk);
         if (just) check(src_wr_ready == 1'b0, "R2", W'(src_wr_ready), W'(0));
         just = 1'b0;
         src_wr_en = ($urandom % 3) != 0;
         src_wr_data = fresh_word(last);
         if (src_wr_en && src_wr_ready) begin
            q.push_back(src_wr_data);
            stamp.push_back(dcount);
            last = src_wr_data;
            accepted++;
            just = 1'b1;
         end else if (src_wr_en) begin
            ignored++;
         end
      end
      @(negedge src_clk);
      src_wr_en = 1'b0;
      drain("R4");
   endtask

   initial begin
      #(200000 * 8);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (5) @(negedge src_clk);
      check(dst_rd_data == INIT, "R1", dst_rd_data, INIT);
      check(src_wr_ready == 1'b1, "R1", W'(src_wr_ready), W'(1));
      src_rst_n = 1'b1;
      repeat (10) @(negedge src_clk);
      check(dst_rd_data == INIT, "R1", dst_rd_data, INIT);
      check(src_wr_ready == 1'b1, "R1", W'(src_wr_ready), W'(1));
      model_on = 1'b1;

      run_phase(4.0, 400);
      run_phase(13.0, 400);
      run_phase(1.7, 400);
      run_phase(23.0, 400);

      // R6: reset with a word in flight
      dst_half = 9.0;
      @(negedge src_clk);
      src_wr_data = fresh_word(last);
      src_wr_en = 1'b1;
      @(negedge src_clk);
      src_wr_en = 1'b0;
      model_on = 1'b0;
      @(negedge src_clk);
      src_rst_n = 1'b0;
      repeat (3) @(negedge src_clk);
      check(dst_rd_data == INIT, "R6", dst_rd_data, INIT);
      check(src_wr_ready == 1'b1, "R6", W'(src_wr_ready), W'(1));
      q.delete();
      stamp.delete();
      cur = INIT;
      last = INIT;
      src_rst_n = 1'b1;
      repeat (10) @(negedge src_clk);
      check(dst_rd_data == INIT, "R6", dst_rd_data, INIT);
      model_on = 1'b1;
      run_phase(6.0, 200);

      check(ignored > 0, "R3", W'(ignored), W'(1));
      check(accepted > 40, "R7", W'(accepted), W'(41));

      model_on = 1'b0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule